// File: doc/BRIEF.md
# Threshold-and-burst DMA channel arbiter

This block decides which of three video DMA channels may master the system bus next. Each channel sits behind its own 128-Dword FIFO and reports that FIFO's current fill level. A channel that moves data into system memory asks for the bus once enough data has piled up in its FIFO. A channel that pulls data out of system memory asks once enough room has opened up. Each channel has its own threshold for this test and its own burst length for the grant it then receives.

Channel 0 can only write to memory. Channels 1 and 2 each have a direction bit that selects reading or writing. Requests are served in round-robin order. A grant is held until the burst finishes. The bus side reports each transferred Dword on `beatValid`, and the arbiter counts those beats against the granted channel's burst length. A burst also ends early when the FIFO can no longer supply or take data. When a burst ends, `burstDone` pulses and the grant is released.

Top module: `dma_burst_arbiter`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `grant` is 0, `burstCount` is 0 and `burstDone` is 0.
- R2: A channel in write direction requests when its fill level is greater than or equal to its threshold. Below the threshold it is never granted.
- R3: A channel in read direction (direction bit = 1, channels 1 and 2 only) requests when the free space, 128 minus the fill level, is greater than or equal to its threshold.
- R4: Channel 0 always behaves as a write channel. Its direction bit has no effect.
- R5: A channel whose enable bit is 0 is never granted, whatever its level.
- R6: `grant` is one-hot or zero. Bit i stands for channel i. It is set on the clock edge after the arbiter is idle and at least one request is present.
- R7: The next grant goes to the first requesting channel after the last granted one, in the order 0, 1, 2, wrapping around. After reset, channel 0 ranks first.
- R8: While a burst is running, `grant` does not change, even if other channels request.
- R9: `burstCount` rises by one on each cycle with `beatValid` high during a grant. When the beat that reaches the burst length is taken, `grant` and `burstCount` return to 0 and `burstDone` is 1 for exactly one cycle.
- R10: A burst ends early, with the same `burstDone` pulse, when the granted write channel's fill level is 0 or the granted read channel's fill level is 128.
- R11: A threshold or burst length above 128 acts as 128. A burst length of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEnable | input | 3 | Per-channel transfer enable |
| chanReadDir | input | 3 | Per-channel direction, 1 = read from memory (bit 0 ignored) |
| fillLevel | input | 24 | Per-channel FIFO fill level in Dwords, 8 bits each, channel i at [8i+7:8i] |
| threshold | input | 24 | Per-channel request threshold, same packing |
| burstLen | input | 24 | Per-channel burst length in Dwords, same packing |
| beatValid | input | 1 | One Dword of the granted channel moved this cycle |
| grant | output | 3 | One-hot bus grant |
| burstCount | output | 8 | Beats taken in the current burst |
| burstDone | output | 1 | One-cycle pulse when a burst ends |

## Verification
The hardest case to reach is a full-length burst under the clamp: a burst length of 250 must behave as exactly 128 beats, with the grant held throughout. The bench keeps `beatValid` high for 127 cycles, confirms that the grant and a count of 127 are still present, and then watches the release on the 128th beat. Early termination is a second awkward case, because it needs the FIFO level to move while a grant is in force. The bench reaches it by raising a channel's level past its threshold, waiting for the grant, and only then forcing that level to empty or full. A round-robin model in the bench tracks the last granted channel across all scenarios, so rotation is checked even when requesters drop out.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef struct packed {
    logic clearCount;
    logic incCount;
  } arbStrobe_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int FIFO_DEPTH = 128,
  parameter int LVL_W = 8,
  parameter logic [NUM_CH-1:0] READ_CAPABLE = 3'b110
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chanEnable,
  input  logic [NUM_CH-1:0]       chanReadDir,
  input  logic [NUM_CH*LVL_W-1:0] fillLevel,
  input  logic [NUM_CH*LVL_W-1:0] threshold,
  input  logic [NUM_CH*LVL_W-1:0] burstLen,
  input  logic [NUM_CH-1:0]       grant,
  input  arbStrobe_t              strobe,
  output logic [NUM_CH-1:0]       chanReq,
  output logic                    lastBeat,
  output logic                    fifoStall,
  output logic [LVL_W-1:0]        burstCount
);
  localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(FIFO_DEPTH);

  logic [NUM_CH-1:0] stallCh;
  logic [NUM_CH-1:0] endCh;
  logic [LVL_W:0]    nextCount;

  assign nextCount = {1'b0, burstCount} + 1'b1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic [LVL_W-1:0] lvl, thrC, lenC, freeSpace;
    logic isRead;
    assign lvl       = fillLevel[i*LVL_W +: LVL_W];
    assign thrC      = (threshold[i*LVL_W +: LVL_W] > DEPTH_V) ? DEPTH_V
                                                              : threshold[i*LVL_W +: LVL_W];
    assign lenC      = (burstLen[i*LVL_W +: LVL_W] > DEPTH_V) ? DEPTH_V :
                       (burstLen[i*LVL_W +: LVL_W] == '0) ? LVL_W'(1)
                                                           : burstLen[i*LVL_W +: LVL_W];
    assign isRead    = READ_CAPABLE[i] & chanReadDir[i];
    assign freeSpace = (lvl >= DEPTH_V) ? '0 : DEPTH_V - lvl;
    assign chanReq[i] = chanEnable[i] & (isRead ? (freeSpace >= thrC) : (lvl >= thrC));
    assign stallCh[i] = isRead ? (lvl >= DEPTH_V) : (lvl == '0);
    assign endCh[i]   = nextCount >= {1'b0, lenC};
  end

  assign fifoStall = |(stallCh & grant);
  assign lastBeat  = |(endCh & grant);

  always_ff @(posedge clk) begin
    if (!rstN)                 burstCount <= '0;
    else if (strobe.clearCount) burstCount <= '0;
    else if (strobe.incCount)   burstCount <= nextCount[LVL_W-1:0];
  end
endmodule

// File: rtl/arb_control.sv
module arb_control
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanReq,
  input  logic              lastBeat,
  input  logic              fifoStall,
  input  logic              beatValid,
  output logic [NUM_CH-1:0] grant,
  output logic              burstDone,
  output arbStrobe_t        strobe
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [IDX_W-1:0] lastIdx, pickIdx;
  logic             pickFound, busy, endBurst;

  assign busy     = |grant;
  assign endBurst = busy & (fifoStall | (beatValid & lastBeat));

  always_comb begin
    pickIdx   = lastIdx;
    pickFound = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      int c;
      c = (int'(lastIdx) + k) % NUM_CH;
      if (!pickFound && chanReq[c]) begin
        pickFound = 1'b1;
        pickIdx   = IDX_W'(c);
      end
    end
  end

  always_comb begin
    strobe.clearCount = ~busy | endBurst;
    strobe.incCount   = busy & beatValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant     <= '0;
      burstDone <= 1'b0;
      lastIdx   <= IDX_W'(NUM_CH - 1);
    end else begin
      burstDone <= 1'b0;
      if (!busy) begin
        if (pickFound) begin
          grant   <= NUM_CH'(1) << pickIdx;
          lastIdx <= pickIdx;
        end
      end else if (endBurst) begin
        grant     <= '0;
        burstDone <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int FIFO_DEPTH = 128,
  parameter logic [NUM_CH-1:0] READ_CAPABLE = 3'b110,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chanEnable,
  input  logic [NUM_CH-1:0]       chanReadDir,
  input  logic [NUM_CH*LVL_W-1:0] fillLevel,
  input  logic [NUM_CH*LVL_W-1:0] threshold,
  input  logic [NUM_CH*LVL_W-1:0] burstLen,
  input  logic                    beatValid,
  output logic [NUM_CH-1:0]       grant,
  output logic [LVL_W-1:0]        burstCount,
  output logic                    burstDone
);
  arbStrobe_t        strobe;
  logic [NUM_CH-1:0] chanReq;
  logic              lastBeat, fifoStall;

  arb_datapath #(
    .NUM_CH(NUM_CH), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .READ_CAPABLE(READ_CAPABLE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .chanReadDir(chanReadDir),
    .fillLevel(fillLevel), .threshold(threshold), .burstLen(burstLen),
    .grant(grant), .strobe(strobe), .chanReq(chanReq), .lastBeat(lastBeat),
    .fifoStall(fifoStall), .burstCount(burstCount)
  );

  arb_control #(.NUM_CH(NUM_CH)) u_control (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .lastBeat(lastBeat),
    .fifoStall(fifoStall), .beatValid(beatValid), .grant(grant),
    .burstDone(burstDone), .strobe(strobe)
  );
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NUM_CH = 3,
  parameter int LVL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chanEnable,
  input logic [NUM_CH-1:0] grant,
  input logic [LVL_W-1:0]  burstCount,
  input logic              burstDone
);
  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |=> (grant == $past(grant)) || (grant == '0));

  // R9
  done_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> (grant == '0) && (burstCount == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);

  // R9
  idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant == '0) |-> (burstCount == '0));

  // R5
  enabled_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|grant) |-> |(grant & $past(chanEnable)));
endmodule

bind dma_burst_arbiter dma_arb_checker #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_arbChecker (
  .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .grant(grant),
  .burstCount(burstCount), .burstDone(burstDone)
);

// File: tb/dma_burst_arbiter_bench.sv
module dma_burst_arbiter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  chanEnable = '0;
  logic [2:0]  chanReadDir = '0;
  logic [23:0] fillLevel, threshold, burstLen;
  logic        beatValid = 1'b0;
  logic [2:0]  grant;
  logic [7:0]  burstCount;
  logic        burstDone;

  logic [7:0] fillA [3];
  logic [7:0] thrA  [3];
  logic [7:0] lenA  [3];

  int testCount = 0;
  int failCount = 0;
  int rrLast = 2;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      fillLevel[i*8 +: 8] = fillA[i];
      threshold[i*8 +: 8] = thrA[i];
      burstLen[i*8 +: 8]  = lenA[i];
    end
  end

  dma_burst_arbiter u_dma_burst_arbiter (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .chanReadDir(chanReadDir),
    .fillLevel(fillLevel), .threshold(threshold), .burstLen(burstLen),
    .beatValid(beatValid), .grant(grant), .burstCount(burstCount), .burstDone(burstDone)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pickRr(input int mask);
    for (int k = 1; k <= 3; k++) begin
      int c;
      c = (rrLast + k) % 3;
      if (mask[c]) return c;
    end
    return -1;
  endfunction

  task automatic expectGrant(input int ch, input string tag);
    chk(grant == 3'(1 << ch), tag, int'(grant), 1 << ch);
    rrLast = ch;
  endtask

  task automatic setChan(input int i, input bit en, input bit rd,
                         input int fill, input int thr, input int len);
    chanEnable[i]  = en;
    chanReadDir[i] = rd;
    fillA[i] = 8'(fill);
    thrA[i]  = 8'(thr);
    lenA[i]  = 8'(len);
  endtask

  task automatic quiet();
    for (int i = 0; i < 3; i++) setChan(i, 0, 0, 0, 0, 1);
    beatValid = 1'b0;
    tick();
    tick();
  endtask

  task automatic singleBeatFinish(input string tag);
    beatValid = 1'b1;
    tick();
    chk(burstDone && grant == 0, tag, int'(burstDone), 1);
    quiet();
  endtask

  task automatic testReset();
    quiet();
    chk(grant == 0, "R1 grant", int'(grant), 0);
    chk(burstCount == 0, "R1 count", int'(burstCount), 0);
    chk(burstDone == 0, "R1 done", int'(burstDone), 0);
    rstN = 1'b1;
    tick();
    chk(grant == 0 && burstDone == 0, "R1 after release", int'(grant), 0);
  endtask

  task automatic testWriteThreshold();
    setChan(1, 1, 0, 9, 10, 1);
    tick(); tick();
    chk(grant == 0, "R2 below threshold", int'(grant), 0);
    fillA[1] = 8'd10;
    tick();
    expectGrant(1, "R2 at threshold");
    singleBeatFinish("R2 finish");
  endtask

  task automatic testReadThreshold();
    setChan(2, 1, 1, 29, 100, 1);
    tick(); tick();
    chk(grant == 0, "R3 free below threshold", int'(grant), 0);
    fillA[2] = 8'd28;
    tick();
    expectGrant(2, "R3 free at threshold");
    singleBeatFinish("R3 finish");
  endtask

  task automatic testWriteOnly();
    setChan(0, 1, 1, 100, 50, 1);
    tick();
    expectGrant(0, "R4 direction bit ignored");
    singleBeatFinish("R4 finish");
  endtask

  task automatic testDisabled();
    setChan(1, 0, 0, 128, 1, 1);
    tick(); tick(); tick();
    chk(grant == 0, "R5 disabled channel", int'(grant), 0);
    quiet();
  endtask

  task automatic testRoundRobin();
    for (int i = 0; i < 3; i++) setChan(i, 1, 0, 60, 5, 1);
    beatValid = 1'b1;
    for (int n = 0; n < 4; n++) begin
      int g;
      g = pickRr(7);
      tick();
      expectGrant(g, "R7 rotation all requesting");
      chk($onehot(grant), "R6 one-hot", int'(grant), 1 << g);
      tick();
      chk(burstDone == 1, "R9 single-beat done", int'(burstDone), 1);
    end
    chanEnable[1] = 1'b0;
    for (int n = 0; n < 3; n++) begin
      int g;
      g = pickRr(5);
      tick();
      expectGrant(g, "R7 rotation skips idle channel");
      tick();
    end
    quiet();
  endtask

  task automatic testBurstHold();
    int g;
    setChan(0, 1, 0, 60, 5, 3);
    setChan(1, 1, 0, 60, 5, 3);
    g = pickRr(3);
    tick();
    expectGrant(g, "R6 grant after request");
    beatValid = 1'b1;
    tick();
    chk(burstCount == 1, "R9 count first beat", int'(burstCount), 1);
    chk(grant == 3'(1 << g), "R8 held beat 1", int'(grant), 1 << g);
    beatValid = 1'b0;
    tick();
    chk(burstCount == 1, "R9 no count without beat", int'(burstCount), 1);
    chk(grant == 3'(1 << g), "R8 held while stalled", int'(grant), 1 << g);
    beatValid = 1'b1;
    tick();
    chk(burstCount == 2, "R9 count second beat", int'(burstCount), 2);
    tick();
    chk(grant == 0 && burstDone == 1 && burstCount == 0, "R9 release at length",
        int'(grant), 0);
    for (int i = 0; i < 3; i++) chanEnable[i] = 1'b0;
    beatValid = 1'b0;
    tick();
    chk(burstDone == 0, "R9 done is one cycle", int'(burstDone), 0);
    quiet();
  endtask

  task automatic testEarlyEnd();
    setChan(0, 1, 0, 50, 10, 10);
    tick();
    expectGrant(0, "R10 write grant");
    fillA[0] = 8'd0;
    tick();
    chk(grant == 0 && burstDone == 1, "R10 write empty ends burst", int'(burstDone), 1);
    quiet();
    setChan(2, 1, 1, 0, 10, 10);
    tick();
    expectGrant(2, "R10 read grant");
    fillA[2] = 8'd128;
    tick();
    chk(grant == 0 && burstDone == 1, "R10 read full ends burst", int'(burstDone), 1);
    quiet();
  endtask

  task automatic testClamp();
    setChan(0, 1, 0, 128, 200, 250);
    tick();
    expectGrant(0, "R11 threshold clamped");
    beatValid = 1'b1;
    repeat (127) tick();
    chk(grant == 3'b001 && burstCount == 127, "R11 still granted at 127",
        int'(burstCount), 127);
    tick();
    chk(grant == 0 && burstDone == 1, "R11 length clamped to 128", int'(grant), 0);
    beatValid = 1'b0;
    lenA[0] = 8'd0;
    tick();
    expectGrant(0, "R11 zero length grant");
    singleBeatFinish("R11 zero length acts as one");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      fillA[i] = '0; thrA[i] = '0; lenA[i] = 8'd1;
    end
    testReset();
    testWriteThreshold();
    testReadThreshold();
    testWriteOnly();
    testDisabled();
    testRoundRobin();
    testBurstHold();
    testEarlyEnd();
    testClamp();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #1600000;
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule